// File: doc/BRIEF.md
# Minute-Resolution Activity Watchdog

This block is a watchdog built around a down counter that loses one unit per minute. A prescaler turns the system clock into a one-minute tick. Its length is the product of two parameters, the clock frequency in hertz and the number of seconds in one unit. Software programs a reload value through a small register port. Once that value is non-zero, the counter runs down from it. Activity on the keyboard or mouse interrupt lines pushes the deadline back: each such pulse reloads the counter from the stored value.

When a tick takes the counter from one to zero, the block sets a sticky expiry flag. The flag feeds two outputs, an interrupt and a request toward the indicator LED logic, and each output has its own enable bit. The counter then rests at zero until the next reload. Writing zero to the reload register halts the timer without raising an expiry. Every reload also restarts the prescaler, so a full unit always passes before the first decrement.

Top module: `minute_watchdog`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the reload value, the live count, the expiry flag and both enable bits. `irq` and `led_req` are low after reset.
- R2: A write of a non-zero value V to offset 0 stores V as the reload value and loads V into the live counter at the same clock edge. Offset 0 reads back the stored value and offset 3 reads the live counter.
- R3: With no reload, the live counter falls by one every T clock cycles, where T = CLK_HZ × UNIT_SECONDS. The first decrement lands exactly T edges after the reload edge.
- R4: A rising edge on `kbd_act` or on `mouse_act` reloads the live counter from the stored value and restarts the prescaler. When the stored value is zero, the edge has no effect.
- R5: Writing zero to offset 0 sets the live counter to zero and stops it. No expiry flag is set while the timer is stopped.
- R6: A tick that takes the live counter from 1 to 0 sets the expiry flag, read at offset 1 bit 0. The counter then stays at 0. The flag holds until a write to offset 1 with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. If a set and a clear land on the same edge, the set wins.
- R7: `irq` is high exactly while the expiry flag is set and the interrupt enable is set. The interrupt enable is offset 2 bit 0 and reads back there.
- R8: `led_req` is high exactly while the expiry flag is set and the LED enable is set. The LED enable is offset 2 bit 1 and reads back there.
- R9: When a register write to offset 0 and an activity edge arrive in the same cycle, the written value is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | CNT_W | Register read data (combinational) |
| kbd_act | input | 1 | Keyboard interrupt activity line |
| mouse_act | input | 1 | Mouse interrupt activity line |
| irq | output | 1 | Expiry interrupt |
| led_req | output | 1 | Expiry request toward LED blink logic |

## Verification
The countdown is tried in several ways: an undisturbed run to expiry, runs interrupted by keyboard pulses and by mouse pulses, a one-unit load, and a full-scale load of 255. Between them these runs separate a late or early first decrement from a correct one, and a restarting prescaler from a free-running one. A zero write followed by activity pulses shows a stopped timer apart from one that reloads or expires spuriously. A write that coincides with a mouse edge shows which reload source has priority. W1C writes with bit 0 clear and then set tell a sticky flag apart from one that drops on any write. Each of these phases runs under different enable settings, so the interrupt gate and the LED gate are observed separately.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      REG_RELOAD = 2'd0,
      REG_STATUS = 2'd1,
      REG_CTRL   = 2'd2,
      REG_LIVE   = 2'd3
   } wdt_reg_e;

   localparam int STAT_EXPIRED_BIT = 0;
   localparam int CTRL_IRQ_BIT     = 0;
   localparam int CTRL_LED_BIT     = 1;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter longint unsigned TICKS = 64'd3000000000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);

   localparam int PRE_W = (TICKS > 64'd1) ? $clog2(TICKS) : 1;

   generate
      if (TICKS <= 64'd1) begin : g_every_cycle
         logic unused_inputs;
         assign unused_inputs = clk ^ rst ^ restart;
         assign tick = 1'b1;
      end else begin : g_count
         localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS - 64'd1);
         logic [PRE_W-1:0] pre;

         always_ff @(posedge clk) begin
            if (rst || restart) begin
               pre <= '0;
            end else if (pre == LAST) begin
               pre <= '0;
            end else begin
               pre <= pre + 1'b1;
            end
         end

         assign tick = (pre == LAST);

         // R3: a restart pushes the next tick at least one full unit away
         assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
            restart |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/wdt_activity.sv
module wdt_activity #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic kbd_act,
   input  logic mouse_act,
   output logic hit
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic kbd_q, mouse_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               kbd_q   <= 1'b0;
               mouse_q <= 1'b0;
            end else begin
               kbd_q   <= kbd_act;
               mouse_q <= mouse_act;
            end
         end
         assign hit = (kbd_act & ~kbd_q) | (mouse_act & ~mouse_q);
      end else begin : g_level
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst;
         assign hit = kbd_act | mouse_act;
      end
   endgenerate

endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (tick && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expire = tick && !load && (cnt == ONE);

   // R6: an idle counter at zero never wraps
   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0 && !load) |=> (cnt == '0));

   // R3: without a tick or load the count holds
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && !tick) |=> $stable(cnt));

   // R3: a tick on a running counter removes exactly one unit
   assert_step_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             expire,
   output logic [CNT_W-1:0] reload_q,
   output logic             expired,
   output logic             irq_en,
   output logic             led_en
);

   logic wr_reload, wr_status, wr_ctrl, clr_req;

   assign wr_reload = wr_en && (wr_addr == REG_RELOAD);
   assign wr_status = wr_en && (wr_addr == REG_STATUS);
   assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
   assign clr_req   = wr_status && wr_data[STAT_EXPIRED_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         reload_q <= '0;
         irq_en   <= 1'b0;
         led_en   <= 1'b0;
      end else begin
         if (wr_reload) reload_q <= wr_data;
         if (wr_ctrl) begin
            irq_en <= wr_data[CTRL_IRQ_BIT];
            led_en <= wr_data[CTRL_LED_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         expired <= 1'b0;
      end else if (expire) begin
         expired <= 1'b1;
      end else if (clr_req) begin
         expired <= 1'b0;
      end
   end

   // R6: the flag only drops on an explicit clear
   assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (expired && !clr_req) |=> expired);

   // R6: an expiry always lands in the flag
   assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
      expire |=> expired);

endmodule

// File: rtl/minute_watchdog.sv
module minute_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 50_000_000,
   parameter int unsigned UNIT_SECONDS = 60,
   parameter int          CNT_W        = 8,
   parameter bit          ACT_EDGE     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             kbd_act,
   input  logic             mouse_act,
   output logic             irq,
   output logic             led_req
);

   localparam longint unsigned TICKS = longint'(CLK_HZ) * longint'(UNIT_SECONDS);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("minute_watchdog: CNT_W must lie in 2..32");
      end
      if (TICKS == 64'd0) begin : g_bad_ticks
         $error("minute_watchdog: CLK_HZ and UNIT_SECONDS must be non-zero");
      end
   endgenerate

   logic             act_hit, wr_count, load, tick, expire;
   logic             expired, irq_en, led_en;
   logic [CNT_W-1:0] reload_q, live, load_val;

   assign wr_count = wr_en && (wr_addr == REG_RELOAD);
   assign load     = wr_count || (act_hit && (reload_q != '0));
   assign load_val = wr_count ? wr_data : reload_q;

   wdt_activity #(.EDGE_MODE(ACT_EDGE)) u_act (
      .clk(clk), .rst(rst), .kbd_act(kbd_act), .mouse_act(mouse_act), .hit(act_hit)
   );

   wdt_prescaler #(.TICKS(TICKS)) u_pre (
      .clk(clk), .rst(rst), .restart(load), .tick(tick)
   );

   wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(load), .load_val(load_val),
      .tick(tick), .cnt(live), .expire(expire)
   );

   wdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .expire(expire), .reload_q(reload_q), .expired(expired),
      .irq_en(irq_en), .led_en(led_en)
   );

   always_comb begin
      rd_data = '0;
      case (wdt_reg_e'(rd_addr))
         REG_RELOAD: rd_data = reload_q;
         REG_STATUS: rd_data[STAT_EXPIRED_BIT] = expired;
         REG_CTRL: begin
            rd_data[CTRL_IRQ_BIT] = irq_en;
            rd_data[CTRL_LED_BIT] = led_en;
         end
         default:    rd_data = live;
      endcase
   end

   assign irq     = expired && irq_en;
   assign led_req = expired && led_en;

   // R9: a register write beats a coincident activity reload
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == REG_RELOAD) |=> (live == $past(wr_data)));

   // R4: activity with a zero reload value leaves a stopped counter at zero
   assert_idle_activity_R4: assert property (@(posedge clk) disable iff (rst)
      (act_hit && !wr_en && reload_q == '0 && live == '0) |=> (live == '0));

endmodule

// File: tb/tb_minute_watchdog.sv
module tb_minute_watchdog;

   localparam int HZ = 4;
   localparam int SECS = 5;
   localparam int T = HZ * SECS;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = 2'd0;
   logic [W-1:0] rd_data;
   logic         kbd_act = 1'b0;
   logic         mouse_act = 1'b0;
   logic         irq, led_req;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   int steps = 0;
   bit compare_on = 1'b0;

   // reference model state
   int m_reload = 0, m_live = 0, m_pre = 0;
   bit m_flag = 0, m_ie = 0, m_le = 0, m_kq = 0, m_mq = 0;

   minute_watchdog #(.CLK_HZ(HZ), .UNIT_SECONDS(SECS), .CNT_W(W), .ACT_EDGE(1'b1)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .kbd_act(kbd_act), .mouse_act(mouse_act),
      .irq(irq), .led_req(led_req)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      bit edge_hit, tick, set_flag;
      edge_hit = (kbd_act && !m_kq) || (mouse_act && !m_mq);
      m_kq = kbd_act;
      m_mq = mouse_act;
      if (rst) begin
         m_reload = 0; m_live = 0; m_pre = 0; m_flag = 0; m_ie = 0; m_le = 0;
         m_kq = 0; m_mq = 0;
      end else begin
         tick = (m_pre == T - 1);
         set_flag = 0;
         if (wr_en && wr_addr == 2'd0) begin
            m_reload = int'(wr_data); m_live = int'(wr_data); m_pre = 0;
         end else if (edge_hit && m_reload != 0) begin
            m_live = m_reload; m_pre = 0;
         end else begin
            m_pre = tick ? 0 : m_pre + 1;
            if (tick && m_live != 0) begin
               m_live = m_live - 1;
               if (m_live == 0) set_flag = 1;
            end
         end
         if (set_flag) m_flag = 1;
         else if (wr_en && wr_addr == 2'd1 && wr_data[0]) m_flag = 0;
         if (wr_en && wr_addr == 2'd2) begin
            m_ie = wr_data[0]; m_le = wr_data[1];
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int model_read(input logic [1:0] a);
      case (a)
         2'd0: return m_reload;
         2'd1: return int'(m_flag);
         2'd2: return int'(m_ie) | (int'(m_le) << 1);
         default: return m_live;
      endcase
   endfunction

   task automatic step();
      @(negedge clk);
      if (compare_on) begin
         chk("R7 irq", int'(irq), int'(m_flag && m_ie));
         chk("R8 led_req", int'(led_req), int'(m_flag && m_le));
         case (rd_addr)
            2'd0: chk("R2 reload readback", int'(rd_data), model_read(rd_addr));
            2'd1: chk("R6 status readback", int'(rd_data), model_read(rd_addr));
            2'd2: chk("R7 ctrl readback", int'(rd_data), model_read(rd_addr));
            default: chk("R3 live count", int'(rd_data), model_read(rd_addr));
         endcase
      end
      steps++;
      rd_addr = 2'(steps % 4);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      step();
      wr_en = 1'b0;
   endtask

   task automatic pulse_kbd();
      kbd_act = 1'b1; step(); kbd_act = 1'b0;
   endtask

   task automatic pulse_mouse();
      mouse_act = 1'b1; step(); mouse_act = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL R3 watchdog expired actual=%0d expected<=150000", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      rst = 1'b1;
      run(3);
      rst = 1'b0;
      compare_on = 1'b1;
      // R1: everything cleared after reset
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), v);
         chk("R1 reset register", v, 0);
      end
      chk("R1 reset irq", int'(irq), 0);
      chk("R1 reset led_req", int'(led_req), 0);

      // R2 / R3: load 3 and watch the first decrement
      wr(2'd0, 3);
      peek(2'd3, v); chk("R2 live after write", v, 3);
      peek(2'd0, v); chk("R2 stored after write", v, 3);
      run(T - 1);
      peek(2'd3, v); chk("R3 no decrement before T", v, 3);
      run(1);
      peek(2'd3, v); chk("R3 decrement at T", v, 2);

      // R4: keyboard and mouse reloads restart the full period
      run(5);
      pulse_kbd();
      peek(2'd3, v); chk("R4 kbd reload", v, 3);
      run(T - 1);
      peek(2'd3, v); chk("R4 prescaler restarted", v, 3);
      run(7);
      pulse_mouse();
      peek(2'd3, v); chk("R4 mouse reload", v, 3);

      // R6 / R7: run to expiry with interrupt enabled
      wr(2'd2, 1);
      run(3 * T);
      peek(2'd3, v); chk("R6 counter at zero", v, 0);
      peek(2'd1, v); chk("R6 flag set", v, 1);
      chk("R7 irq asserted", int'(irq), 1);
      chk("R8 led_req gated off", int'(led_req), 0);
      run(2 * T);
      peek(2'd3, v); chk("R6 no wrap", v, 0);
      peek(2'd1, v); chk("R6 flag sticky", v, 1);
      wr(2'd1, 0);
      peek(2'd1, v); chk("R6 write of 0 keeps flag", v, 1);
      wr(2'd1, 1);
      peek(2'd1, v); chk("R6 W1C clears flag", v, 0);
      chk("R7 irq drops", int'(irq), 0);

      // R8: LED enable only
      wr(2'd2, 2);
      wr(2'd0, 1);
      run(T);
      chk("R8 led_req asserted", int'(led_req), 1);
      chk("R7 irq gated off", int'(irq), 0);
      wr(2'd1, 1);

      // R5: zero write stops the timer; activity is ignored
      wr(2'd0, 4);
      run(T + 3);
      wr(2'd0, 0);
      peek(2'd3, v); chk("R5 stopped at zero", v, 0);
      pulse_kbd();
      pulse_mouse();
      peek(2'd3, v); chk("R4 activity ignored when stored zero", v, 0);
      run(3 * T);
      peek(2'd1, v); chk("R5 no expiry while stopped", v, 0);
      chk("R5 led_req low while stopped", int'(led_req), 0);

      // R9: write and activity in the same cycle
      wr(2'd0, 2);
      run(4);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd7; mouse_act = 1'b1;
      step();
      wr_en = 1'b0; mouse_act = 1'b0;
      peek(2'd3, v); chk("R9 write wins over activity", v, 7);

      // R3: full-scale load, held level activity reloads only once
      wr(2'd0, 255);
      run(T);
      peek(2'd3, v); chk("R3 full-scale first step", v, 254);
      kbd_act = 1'b1;
      run(T + 5);
      kbd_act = 1'b0;
      peek(2'd3, v); chk("R4 held line reloads once", v, 254);
      run(T);

      summary();
      $finish;
   end

endmodule